// File: doc/BRIEF.md
# Return-Address Stack with Occupancy Watermark Interrupt

This block is a last-in, first-out store for program-counter return values, 33 entries deep by default. The sequencer pushes a return address on a call or interrupt entry and pops it on return. The block reports its current fill level and flags for empty and full. It also drives a stack-level interrupt request, so that software can spill entries to memory before the stack overflows, or refill them before it runs dry.

The request is a level output. It is high while the enable input is set and the fill level is below a low watermark (fewer than 3 entries) or above a high watermark (more than 28 entries). The enable input models one bit of the interrupt control register. Illegal operations do not change the stored contents: a push into a full stack and a pop from an empty one are dropped. Each of them sets its own sticky error flag, which stays set until reset.

Top module: `pc_ret_stack`

## Requirements
- R1: After reset the fill level is 0, the empty flag is 1, the full flag is 0, both error flags are 0, and the top-of-stack output is 0.
- R2: A push alone on a non-full stack stores the pushed value on top and raises the fill level by one at the next clock edge.
- R3: A pop alone on a non-empty stack lowers the fill level by one, and values come back in reverse order of pushing.
- R4: A push and a pop in the same cycle on a non-empty stack overwrite the top entry with the pushed value and leave the fill level unchanged. This also holds when the stack is full.
- R5: A push alone on a full stack is ignored (level and contents unchanged) and sets the overflow flag, which stays set until reset.
- R6: A pop on an empty stack is ignored and sets the underflow flag, which stays set until reset. A push and a pop together on an empty stack act as a plain push and also set the underflow flag.
- R7: The empty flag is 1 exactly when the level is 0, and the full flag is 1 exactly when the level equals the depth (33).
- R8: With the enable set, the interrupt request is 1 whenever the level is below 3.
- R9: With the enable set, the interrupt request is 1 whenever the level is above 28.
- R10: The interrupt request is 0 when the enable is clear, and also when the level lies between 3 and 28 inclusive. It follows the enable input within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push pushAddr this cycle |
| popReq | input | 1 | Pop the top entry this cycle |
| pushAddr | input | DATA_W | Return address to store |
| levelIrqEn | input | 1 | Stack-level interrupt enable (control register bit) |
| topAddr | output | DATA_W | Current top entry, 0 when empty |
| fillLevel | output | CNT_W | Number of occupied entries |
| isEmpty | output | 1 | Level is 0 |
| isFull | output | 1 | Level equals DEPTH |
| overflowErr | output | 1 | Sticky: a push hit a full stack |
| underflowErr | output | 1 | Sticky: a pop hit an empty stack |
| levelIrq | output | 1 | Watermark interrupt request (level) |

## Verification
A wrong fill counter shows on fillLevel and on the flags at the very next clock edge. It also shifts the interrupt request by one entry around each watermark. A wrong write index or read index does not show on the level at all. It appears on topAddr only when the misplaced entry comes back to the top, which may be many operations later, so the bench compares topAddr after every operation, including long push and pop runs. A wrong decision on a blocked push or pop changes the level and sets an error flag one cycle after the request.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int STK_IDX_MAX_W = 8;

  typedef struct packed {
    logic                     wr;
    logic [STK_IDX_MAX_W-1:0] wrIdx;
    logic                     rdValid;
    logic [STK_IDX_MAX_W-1:0] rdIdx;
  } stkStrobe_t;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH     = 33,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             irqEn,
  output stkStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             isEmpty,
  output logic             isFull,
  output logic             ovfErr,
  output logic             undErr,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_LOW = CNT_W'(LOW_MARK);
  localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(HIGH_MARK);

  logic doReplace, doPush, doPop, pushBlocked, popBlocked;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    isEmpty     = (cnt == '0);
    isFull      = (cnt == CNT_MAX);
    doReplace   = pushReq && popReq && !isEmpty;
    doPush      = pushReq && !doReplace && !isFull;
    doPop       = popReq && !pushReq && !isEmpty;
    pushBlocked = pushReq && !popReq && isFull;
    popBlocked  = popReq && isEmpty;

    strobe.wr      = doReplace || doPush;
    strobe.wrIdx   = doReplace ? STK_IDX_MAX_W'(cnt - 1'b1) : STK_IDX_MAX_W'(cnt);
    strobe.rdValid = !isEmpty;
    strobe.rdIdx   = STK_IDX_MAX_W'(cnt - 1'b1);

    cntNext = cnt;
    if (doPush)     cntNext = cnt + 1'b1;
    else if (doPop) cntNext = cnt - 1'b1;

    irq = irqEn && ((cnt < CNT_LOW) || (cnt > CNT_HIGH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      ovfErr <= 1'b0;
      undErr <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (pushBlocked) ovfErr <= 1'b1;
      if (popBlocked)  undErr <= 1'b1;
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    isFull && pushReq && !popReq |=> isFull && ovfErr);
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty && popReq |=> undErr);
  p_und_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    undErr |=> undErr);
  p_replace_level_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && popReq && !isEmpty |=> $stable(cnt));
  p_irq_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty && irqEn |-> irq);
  p_irq_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    isFull && irqEn |-> irq);
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);
endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int DEPTH  = 33,
  parameter int DATA_W = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  stkStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] topData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wrSel, rdSel;

  assign wrSel = strobe.wrIdx[IDX_W-1:0];
  assign rdSel = strobe.rdIdx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.wr) mem[wrSel] <= wrData;
  end

  always_comb begin
    topData = '0;
    if (strobe.rdValid) topData = mem[rdSel];
  end

  p_write_in_range_r2: assert property (@(posedge clk)
    strobe.wr |-> (32'(wrSel) < DEPTH));
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack
  import stk_pkg::*;
#(
  parameter int DEPTH     = 33,
  parameter int DATA_W    = 16,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 28,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] pushAddr,
  input  logic              levelIrqEn,
  output logic [DATA_W-1:0] topAddr,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              isEmpty,
  output logic              isFull,
  output logic              overflowErr,
  output logic              underflowErr,
  output logic              levelIrq
);
  stkStrobe_t strobe;

  stk_ctrl #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .irqEn(levelIrqEn), .strobe(strobe), .cnt(fillLevel),
    .isEmpty(isEmpty), .isFull(isFull), .ovfErr(overflowErr),
    .undErr(underflowErr), .irq(levelIrq)
  );

  stk_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .strobe(strobe), .wrData(pushAddr), .topData(topAddr)
  );
endmodule

// File: tb/pc_ret_stack_test.sv
`timescale 1ns/1ps
module pc_ret_stack_test;
  localparam int DEPTH = 33;
  localparam int DW    = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0;
  logic rstN = 0;
  logic pushReq = 0, popReq = 0, levelIrqEn = 0;
  logic [DW-1:0] pushAddr = '0;
  logic [DW-1:0] topAddr;
  logic [CW-1:0] fillLevel;
  logic isEmpty, isFull, overflowErr, underflowErr, levelIrq;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cycles = 0;

  logic [DW-1:0] mStk [DEPTH];
  int  mCnt = 0;
  bit  mOvf = 0, mUnd = 0;

  pc_ret_stack uut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushAddr(pushAddr), .levelIrqEn(levelIrqEn), .topAddr(topAddr),
    .fillLevel(fillLevel), .isEmpty(isEmpty), .isFull(isFull),
    .overflowErr(overflowErr), .underflowErr(underflowErr),
    .levelIrq(levelIrq)
  );

  always #5 clk = ~clk;

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      finishRun();
    end
  end

  function automatic bit expIrq(bit en, int c);
    return en && (c < 3 || c > 28);
  endfunction

  function automatic logic [DW-1:0] expTop();
    return (mCnt > 0) ? mStk[mCnt-1] : '0;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string opReq);
    string irqReq;
    irqReq = (mCnt < 3) ? "R8" : (mCnt > 28) ? "R9" : "R10";
    if (!levelIrqEn) irqReq = "R10";
    chk(opReq, "level", fillLevel, mCnt);
    chk(opReq, "top", topAddr, expTop());
    chk("R7", "empty", isEmpty, mCnt == 0);
    chk("R7", "full", isFull, mCnt == DEPTH);
    chk("R5", "overflow", overflowErr, mOvf);
    chk("R6", "underflow", underflowErr, mUnd);
    chk(irqReq, "irq", levelIrq, expIrq(levelIrqEn, mCnt));
  endtask

  task automatic step(bit pu, bit po, logic [DW-1:0] d);
    string req;
    pushReq = pu; popReq = po; pushAddr = d;
    @(posedge clk);
    if (pu && po && mCnt > 0) begin
      mStk[mCnt-1] = d; req = "R4";
    end else if (pu) begin
      if (po) mUnd = 1;
      if (mCnt < DEPTH) begin mStk[mCnt] = d; mCnt++; req = "R2"; end
      else begin mOvf = 1; req = "R5"; end
    end else if (po) begin
      if (mCnt > 0) begin mCnt--; req = "R3"; end
      else begin mUnd = 1; req = "R6"; end
    end else req = "R10";
    #1;
    pushReq = 0; popReq = 0;
    checkAll(req);
  endtask

  task automatic doReset();
    rstN = 0;
    pushReq = 0; popReq = 0;
    repeat (2) @(posedge clk);
    #1;
    rstN = 1;
    mCnt = 0; mOvf = 0; mUnd = 0;
    #1;
    chk("R1", "level", fillLevel, 0);
    chk("R1", "empty", isEmpty, 1);
    chk("R1", "full", isFull, 0);
    chk("R1", "overflow", overflowErr, 0);
    chk("R1", "underflow", underflowErr, 0);
    chk("R1", "top", topAddr, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    levelIrqEn = 1;
    doReset();
    checkAll("R1");
    // fill to full, irq across both watermarks
    for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(16'h1000 + i));
    // enable gating same cycle
    levelIrqEn = 0; #1; checkAll("R10");
    levelIrqEn = 1; #1; checkAll("R9");
    // push when full ignored
    step(1, 0, 16'hDEAD);
    // replace at full
    step(1, 1, 16'hBEEF);
    // drain, LIFO order
    for (int i = 0; i < DEPTH; i++) step(0, 1, '0);
    // pop on empty, then push+pop on empty
    step(0, 1, '0);
    step(1, 1, 16'h4242);
    step(1, 1, 16'h4343);
    step(0, 1, '0);
    // mid-range with enable off and on
    doReset();
    for (int i = 0; i < 10; i++) step(1, 0, DW'($urandom));
    levelIrqEn = 0; #1; checkAll("R10");
    levelIrqEn = 1; #1; checkAll("R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit pu, po;
      r = int'($urandom % 100);
      if (i % 500 == 0) levelIrqEn = $urandom % 4 != 0;
      if ((i / 400) % 2 == 0) begin pu = r < 60; po = r >= 45; end
      else begin pu = r < 40; po = r >= 25; end
      step(pu, po, DW'($urandom));
      if (i == 2000) doReset();
    end
    finishRun();
  end
endmodule